// File: doc/BRIEF.md
# Two-Read One-Write Flip-Flop Register File

This block is a small register file built from discrete flip-flops. It has two read ports and one write port, and all three can be used in the same clock cycle. Each read port is a combinational path from its address to its data output. The write port is synchronous: a register loads on the rising clock edge when the write enable is high. Every register has its own write enable, and each read port has its own selection multiplexer. There is no row-addressed memory array.

A read of the register that is being written in the same cycle returns the contents from before the write. The new value appears on the read ports from the following cycle onward. This old-value behaviour comes from the storage itself: there is no forwarding path from write data to read data. The block is meant to sit inside a datapath that reads two source operands and writes one result every cycle.

Parameters set the number of registers and their width. The defaults are 16 registers of 8 bits each.

Top module: `rf_2r1w`

## Requirements
- R1: A synchronous, active-high reset clears every register to zero at the next rising edge. A write requested in the same cycle as reset is not performed.
- R2: When `wr_en` is high at a rising edge, the register selected by `wr_addr` takes `wr_data`. The new value is visible on any read port from the next cycle.
- R3: When `wr_en` is low, `wr_addr` and `wr_data` have no effect, and every register keeps its value.
- R4: Each read port is combinational. A change of `rd0_addr` or `rd1_addr` shows up on the matching data output within the same cycle, with no clock edge needed.
- R5: The two read ports select registers independently. Both return correct data in a cycle where a third register is being written.
- R6: A read of the register being written in the same cycle returns the value held before the write. The register is not forwarded from `wr_data`.
- R7: When both read ports select the same register, both outputs carry the same value.
- R8: A write changes only the addressed register. All other registers keep their contents.
- R9: With default parameters the file holds 16 registers of 8 bits each. Addresses are 4 bits wide, and register n is selected by address value n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears all registers |
| wr_en | input | 1 | Write enable |
| wr_addr | input | AW (4) | Index of the register to write |
| wr_data | input | W (8) | Value to write |
| rd0_addr | input | AW (4) | Index read by port 0 |
| rd0_data | output | W (8) | Contents of the register selected by port 0 |
| rd1_addr | input | AW (4) | Index read by port 1 |
| rd1_data | output | W (8) | Contents of the register selected by port 1 |

## Verification
The bench builds the block with its defaults: 16 registers of 8 bits. With 16 registers, a random pair of read addresses matches the write address often enough to produce many same-cycle collisions, and the bench also forces collisions on purpose. Full address sweeps after reset and after single writes reach every register through both ports. The 8-bit width allows the all-zeros and all-ones extremes to be written and read back directly.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned RF_NREGS_DEF = 16;
  localparam int unsigned RF_WIDTH_DEF = 8;

  // True when address a selects register index i.
  function automatic logic rf_hit(input int unsigned a, input int unsigned i);
    return (a == i);
  endfunction

  // Low bit of a register's field inside a flattened storage vector.
  function automatic int unsigned rf_lsb(input int unsigned idx, input int unsigned w);
    return idx * w;
  endfunction
endpackage

// File: rtl/rf_wdec.sv
module rf_wdec #(
  parameter int unsigned NREGS = 16,
  parameter int unsigned AW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  output logic [NREGS-1:0] row_we
);
  import rf_pkg::*;

  for (genvar i = 0; i < NREGS; i++) begin : g_dec
    assign row_we[i] = wr_en && !rst && rf_hit(int'(wr_addr), i);
  end

  // At most one register may be enabled for writing per cycle (R8).
  assert_one_row_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_we));

  // With the enable low, no register may be enabled (R3).
  assert_idle_no_row_R3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> (row_we == '0));
endmodule

// File: rtl/rf_row.sv
module rf_row #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end

  // A write lands exactly one edge later (R2).
  assert_row_load_R2: assert property (@(posedge clk) disable iff (rst)
    we |=> (q == $past(d)));

  // An unselected row keeps its value (R8).
  assert_row_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
endmodule

// File: rtl/rf_rmux.sv
module rf_rmux #(
  parameter int unsigned NREGS = 16,
  parameter int unsigned W     = 8,
  parameter int unsigned AW    = 4
) (
  input  logic [NREGS*W-1:0] rows_flat,
  input  logic [AW-1:0]      addr,
  output logic [W-1:0]       data
);
  import rf_pkg::*;

  // AND-OR select: each row is gated by its own decoded hit.
  always_comb begin
    data = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (rf_hit(int'(addr), i))
        data = data | rows_flat[rf_lsb(i, W) +: W];
    end
  end
endmodule

// File: rtl/rf_2r1w.sv
module rf_2r1w #(
  parameter int unsigned NREGS = rf_pkg::RF_NREGS_DEF,
  parameter int unsigned W     = rf_pkg::RF_WIDTH_DEF,
  localparam int unsigned AW   = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd0_addr,
  output logic [W-1:0]  rd0_data,
  input  logic [AW-1:0] rd1_addr,
  output logic [W-1:0]  rd1_data
);
  logic [NREGS-1:0]   row_we;
  logic [NREGS*W-1:0] rows_flat;
  logic [W-1:0]       rows_q [NREGS];

  rf_wdec #(.NREGS(NREGS), .AW(AW)) u_wdec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .row_we(row_we)
  );

  for (genvar i = 0; i < NREGS; i++) begin : g_row
    rf_row #(.W(W)) u_row (
      .clk(clk), .rst(rst), .we(row_we[i]), .d(wr_data), .q(rows_q[i])
    );
    assign rows_flat[i*W +: W] = rows_q[i];
  end

  rf_rmux #(.NREGS(NREGS), .W(W), .AW(AW)) u_rd0 (
    .rows_flat(rows_flat), .addr(rd0_addr), .data(rd0_data)
  );
  rf_rmux #(.NREGS(NREGS), .W(W), .AW(AW)) u_rd1 (
    .rows_flat(rows_flat), .addr(rd1_addr), .data(rd1_data)
  );

  // The addressed register holds the written data after the edge (R2).
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rows_q[$past(wr_addr)] == $past(wr_data)));

  // With the enable low, the whole file is unchanged (R3).
  assert_idle_stable_R3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rows_flat));

  // Two independent muxes agree when they select the same register (R7).
  assert_same_addr_R7: assert property (@(posedge clk) disable iff (rst)
    (rd0_addr == rd1_addr) |-> (rd0_data == rd1_data));

  // A read sampled at a write edge carries the pre-edge contents, and the
  // following cycle shows the written value when the address is held (R6).
  assert_old_then_new_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr == rd0_addr)) |=>
      ($stable(rd0_addr) -> (rd0_data == $past(wr_data))));
endmodule

// File: tb/rf_2r1w_tb.sv
module rf_2r1w_tb;
  localparam int NREGS = 16;
  localparam int W     = 8;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic [AW-1:0] rd0_addr = '0;
  logic [AW-1:0] rd1_addr = '0;
  logic [W-1:0]  rd0_data;
  logic [W-1:0]  rd1_data;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;
  logic [W-1:0] model [NREGS];

  always #5 clk = ~clk;

  rf_2r1w u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd0_addr(rd0_addr), .rd0_data(rd0_data),
    .rd1_addr(rd1_addr), .rd1_data(rd1_data)
  );

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  // One clock: drive at the falling edge, compare reads, then let the edge
  // update the reference model.
  task automatic step(input string req, input logic r, input logic we,
                      input int wa, input logic [W-1:0] wd, input int a0, input int a1);
    @(negedge clk);
    rst = r; wr_en = we; wr_addr = AW'(wa); wr_data = wd;
    rd0_addr = AW'(a0); rd1_addr = AW'(a1);
    #1;
    check(req, rd0_data, model[a0]);
    check(req, rd1_data, model[a1]);
    @(posedge clk);
    if (r) begin
      for (int i = 0; i < NREGS; i++) model[i] = '0;
    end else if (we) begin
      model[wa] = wd;
    end
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < NREGS; i++) step(req, 1'b0, 1'b0, i, 8'h5A, i, NREGS-1-i);
  endtask

  initial begin
    #(200000 * 10);
    misses++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NREGS; i++) model[i] = '0;
    // R1: reset, including a write request during reset
    @(negedge clk); rst = 1'b1;
    @(posedge clk);
    step("R1", 1'b1, 1'b1, 3, 8'hEE, 0, 1);
    #1;
    sweep("R1 after reset");
    // R9: width and depth
    check("R9 width", 8'($bits(rd0_data)), 8'd8);
    check("R9 addr", 8'($bits(rd0_addr)), 8'd4);

    // R2: write every register with a distinct pattern, then read back
    for (int i = 0; i < NREGS; i++) step("R2", 1'b0, 1'b1, i, W'(8'h11 * i + 3), (i + 1) % NREGS, i);
    sweep("R2 readback");

    // R8: a single write touches only one register
    step("R8", 1'b0, 1'b1, 7, 8'hFF, 0, 0);
    sweep("R8");
    step("R8", 1'b0, 1'b1, 7, 8'h00, 7, 6);
    sweep("R8");

    // R3: enable low with moving address/data
    for (int i = 0; i < 20; i++) step("R3", 1'b0, 1'b0, i % NREGS, W'($urandom), i % NREGS, (i * 3) % NREGS);
    sweep("R3");

    // R6: same-cycle read of the written register, then the new value
    for (int i = 0; i < 24; i++) begin
      int a = $urandom_range(NREGS - 1);
      step("R6 collision", 1'b0, 1'b1, a, W'($urandom), a, a);
      step("R6 next", 1'b0, 1'b0, a, 8'h00, a, (a + 5) % NREGS);
    end

    // R7: both ports on the same register
    for (int i = 0; i < NREGS; i++) step("R7", 1'b0, 1'b1, (i + 2) % NREGS, W'($urandom), i, i);

    // R4: address change with no clock edge
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
      rd0_addr = AW'(i); rd1_addr = AW'(15 - i);
      #1;
      check("R4", rd0_data, model[i]);
      check("R4", rd1_data, model[15 - i]);
      rd0_addr = AW'(15 - i); rd1_addr = AW'(i);
      #1;
      check("R4", rd0_data, model[15 - i]);
      check("R4", rd1_data, model[i]);
    end

    // R5: random traffic, two reads plus a write each cycle
    for (int i = 0; i < 400; i++)
      step("R5", 1'b0, ($urandom_range(3) != 0), $urandom_range(NREGS - 1), W'($urandom),
           $urandom_range(NREGS - 1), $urandom_range(NREGS - 1));

    // R1: reset again from a populated file
    step("R1", 1'b1, 1'b0, 0, 8'h00, 2, 9);
    sweep("R1 second reset");

    finish_run();
  end
endmodule